// File: doc/BRIEF.md
# Host Port Ready Handshake Controller

This block is the slave end of a multiplexed 16-bit host port. The host selects the port with an active-low chip select and marks each access with an active-low strobe. A read/write line, a 2-bit register select and a halfword-identify bit describe the access. The block answers on an active-low ready line. Ready is high while the access cannot be completed yet, so the line inserts wait states. It is low once read data is valid or once write data can be taken.

Two targets sit behind the port: a 16-bit control register and a data port. The data port moves 32-bit words as two halfwords, the low half first. Host writes go into a 4-entry write FIFO, which drains to the internal memory side through a request/acknowledge pair. Host reads come from a 4-entry read FIFO. That FIFO fetches words from the memory side while a read is pending and it has room.

While ready is high, the host may retarget the pending access. If the host ends the strobe before ready, the access is aborted. An abort records a sticky flag and leaves both FIFOs untouched.

Top module: `hpi_ready_ctrl`

## Requirements
- R1: During and after reset, `hrdy` is 1, `wr_req` and `rd_req` are 0, and the control register reads 16'h0000.
- R2: In a data read (`hrw`=1, `hcntl`≠00), `hrdy` stays 1 while the read FIFO is empty and `rd_req` is 1 while the read is pending and the FIFO is not full. `hrdy` falls in the cycle after a word is acknowledged with `rd_ack`.
- R3: In a data write (`hrw`=0, `hcntl`≠00), `hrdy` stays 1 while the write FIFO holds 4 words.
- R4: With `hcs_n`=1, `hrdy` is 1 whatever `hstrb_n` does.
- R5: Register select 00 addresses the control register. `hrdy` falls one clock after the strobe falls. `hhwil` has no effect, so either halfword value reads and writes the same register.
- R6: For any nonzero register select, the halfword with `hhwil`=0 carries bits 15:0 of the 32-bit word and the halfword with `hhwil`=1 carries bits 31:16. A FIFO entry is pushed (write) or popped (read) only when the `hhwil`=1 halfword completes.
- R7: While the access is pending with `hrdy`=1 and the strobe low, changed `hcntl`/`hrw`/`hhwil` inputs are relatched each clock and replace the pending access.
- R8: A strobe rising edge while `hrdy`=1 aborts the access. The abort sets control bit 0 and changes neither FIFO. The bit is sticky and is cleared only by writing the control register with bit 0 = 1. Bits 15:1 of the control register are plain storage.
- R9: `wr_req` is 1 while the write FIFO is non-empty. `wr_data` presents the oldest word, and each cycle with `wr_req` and `wr_ack` both 1 removes that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| hstrb_n | input | 1 | Host strobe, active low |
| hrw | input | 1 | 1 = read, 0 = write |
| hcntl | input | 2 | Register select: 00 control, other data port |
| hhwil | input | 1 | Halfword identify: 0 low half, 1 high half |
| hd_in | input | 16 | Host write data |
| hd_out | output | 16 | Host read data |
| hrdy | output | 1 | Ready, active low (1 inserts wait states) |
| wr_req | output | 1 | Write FIFO has a word for memory |
| wr_data | output | 32 | Oldest write FIFO word |
| wr_ack | input | 1 | Memory accepted `wr_data` |
| rd_req | output | 1 | Read FIFO requests a word |
| rd_data | input | 32 | Word from memory |
| rd_ack | input | 1 | `rd_data` valid, push into read FIFO |

## Verification
The internal strobe falling edge is registered, so `hrdy` for a ready target falls at the first clock edge after the host lowers its strobe. The same holds for a relatched control change. `hrdy` also falls in the cycle after an `rd_ack` or `wr_ack` edge clears a FIFO condition. FIFO pushes, pops and control register updates land on the clock edge that sees the strobe rise. The bench drives every input on the falling clock edge and samples each result at the next falling edge after the rising edge that produces it. Where a result must not arrive (wait states, aborts), the bench samples over several consecutive falling edges.

// File: rtl/hpi_ready_ctrl.sv
module hpi_ready_ctrl #(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hcs_n,
  input  logic            hstrb_n,
  input  logic            hrw,
  input  logic [1:0]      hcntl,
  input  logic            hhwil,
  input  logic [DW-1:0]   hd_in,
  output logic [DW-1:0]   hd_out,
  output logic            hrdy,
  output logic            wr_req,
  output logic [2*DW-1:0] wr_data,
  input  logic            wr_ack,
  output logic            rd_req,
  input  logic [2*DW-1:0] rd_data,
  input  logic            rd_ack
);
  localparam int WW = 2 * DW;
  localparam int DEPTH = 1 << AW;

  logic istrb_q, active, c_rw, c_hw, abort_flag;
  logic [1:0] c_sel;
  logic [DW-1:1] ctrl_bits;
  logic [DW-1:0] lo_hold;
  logic [AW:0] wwp, wrp, rwp, rrp;
  logic [WW-1:0] wmem [DEPTH];
  logic [WW-1:0] rmem [DEPTH];

  wire istrb_n = hcs_n | hstrb_n;
  wire fall    = istrb_q & ~istrb_n;
  wire rise    = ~istrb_q & istrb_n;
  wire wempty  = (wwp == wrp);
  wire wfull   = (wwp[AW] != wrp[AW]) && (wwp[AW-1:0] == wrp[AW-1:0]);
  wire rempty  = (rwp == rrp);
  wire rfull   = (rwp[AW] != rrp[AW]) && (rwp[AW-1:0] == rrp[AW-1:0]);
  wire is_ctrl = (c_sel == 2'b00);
  wire ok      = is_ctrl | (c_rw ? ~rempty : ~wfull);
  wire done    = rise & active;
  wire commit  = done & ok;
  wire abort   = done & ~ok;
  wire push_w  = commit & ~is_ctrl & ~c_rw & c_hw;
  wire pop_r   = commit & ~is_ctrl & c_rw & c_hw;
  wire pop_w   = wr_req & wr_ack;
  wire push_r  = rd_req & rd_ack;
  wire [WW-1:0] rhead = rmem[rrp[AW-1:0]];

  assign hrdy    = ~(active & ~hcs_n & ok);
  assign wr_req  = ~wempty;
  assign wr_data = wmem[wrp[AW-1:0]];
  assign rd_req  = ~rfull & active & ~is_ctrl & c_rw;
  assign hd_out  = is_ctrl ? {ctrl_bits, abort_flag}
                 : (c_hw ? rhead[WW-1:DW] : rhead[DW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istrb_q    <= 1'b1;
      active     <= 1'b0;
      c_sel      <= 2'b00;
      c_rw       <= 1'b0;
      c_hw       <= 1'b0;
      ctrl_bits  <= '0;
      abort_flag <= 1'b0;
      lo_hold    <= '0;
      wwp        <= '0;
      wrp        <= '0;
      rwp        <= '0;
      rrp        <= '0;
    end else begin
      istrb_q <= istrb_n;
      if (fall || (active && !ok && !istrb_n)) begin
        c_sel <= hcntl;
        c_rw  <= hrw;
        c_hw  <= hhwil;
      end
      if (fall) active <= 1'b1;
      else if (done) active <= 1'b0;
      if (commit && is_ctrl && !c_rw) begin
        ctrl_bits <= hd_in[DW-1:1];
        if (hd_in[0]) abort_flag <= 1'b0;
      end
      if (abort) abort_flag <= 1'b1;
      if (commit && !is_ctrl && !c_rw && !c_hw) lo_hold <= hd_in;
      if (push_w) wwp <= wwp + 1'b1;
      if (pop_w)  wrp <= wrp + 1'b1;
      if (push_r) rwp <= rwp + 1'b1;
      if (pop_r)  rrp <= rrp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_w) wmem[wwp[AW-1:0]] <= {hd_in, lo_hold};
    if (push_r) rmem[rwp[AW-1:0]] <= rd_data;
  end
endmodule

module hpi_ready_ctrl_chk #(
  parameter int AW = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hcs_n,
  input logic        hrdy,
  input logic        rise,
  input logic        active,
  input logic [1:0]  c_sel,
  input logic        c_rw,
  input logic        rempty,
  input logic        wfull,
  input logic        abort_flag,
  input logic        hd_in0,
  input logic        wr_req,
  input logic        wr_ack,
  input logic [AW:0] wwp,
  input logic [AW:0] wrp
);
  assert_cs_gates_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hcs_n |-> hrdy);
  assert_read_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hrdy && c_sel != 2'b00 && c_rw) |-> !rempty);
  assert_write_needs_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hrdy && c_sel != 2'b00 && !c_rw) |-> !wfull);
  assert_abort_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && active && hrdy) |=> abort_flag);
  assert_abort_keeps_fifo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && active && hrdy && !(wr_req && wr_ack)) |=> ($stable(wwp) && $stable(wrp)));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !(rise && active && c_sel == 2'b00 && !c_rw && hd_in0)) |=> abort_flag);
endmodule

bind hpi_ready_ctrl hpi_ready_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrdy(hrdy), .rise(rise),
  .active(active), .c_sel(c_sel), .c_rw(c_rw), .rempty(rempty), .wfull(wfull),
  .abort_flag(abort_flag), .hd_in0(hd_in[0]), .wr_req(wr_req), .wr_ack(wr_ack),
  .wwp(wwp), .wrp(wrp)
);

// File: tb/hpi_ready_ctrl_bench.sv
module hpi_ready_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {sel[35:34], rw[33], hw[32], wdata[31:16], expected read[15:0]}
  localparam logic [35:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 16'hA5A4, 16'h0000},
    {2'b00, 1'b1, 1'b1, 16'h0000, 16'hA5A4},
    {2'b00, 1'b0, 1'b1, 16'h3C3C, 16'h0000},
    {2'b00, 1'b1, 1'b0, 16'h0000, 16'h3C3C},
    {2'b00, 1'b1, 1'b1, 16'h0000, 16'h3C3C},
    {2'b01, 1'b0, 1'b0, 16'h1111, 16'h0000},
    {2'b01, 1'b0, 1'b1, 16'h2222, 16'h0000},
    {2'b11, 1'b0, 1'b0, 16'h3333, 16'h0000},
    {2'b10, 1'b0, 1'b1, 16'h4444, 16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic hcs_n = 1, hstrb_n = 1, hrw = 0, hhwil = 0, wr_ack = 0, rd_ack = 0;
  logic [1:0] hcntl = 0;
  logic [15:0] hd_in = 0;
  logic [15:0] hd_out;
  logic hrdy, wr_req, rd_req;
  logic [31:0] wr_data;
  logic [31:0] rd_data = 0;
  int checks = 0, errors = 0, cyc = 0;
  logic got;

  hpi_ready_ctrl u_hpi_ready_ctrl (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hstrb_n(hstrb_n), .hrw(hrw),
    .hcntl(hcntl), .hhwil(hhwil), .hd_in(hd_in), .hd_out(hd_out), .hrdy(hrdy),
    .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_data(rd_data), .rd_ack(rd_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] s, input logic rw, input logic hw, input logic [15:0] d);
    @(negedge clk);
    hcntl = s; hrw = rw; hhwil = hw; hd_in = d;
    hcs_n = 0; hstrb_n = 0;
  endtask

  task automatic wait_ready(input int lim, output logic ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!hrdy) begin ok = 1; break; end
    end
  endtask

  task automatic finish_cyc;
    hstrb_n = 1;
    @(negedge clk);
    hcs_n = 1;
    @(negedge clk);
  endtask

  task automatic access(input logic [1:0] s, input logic rw, input logic hw,
                        input logic [15:0] d, input logic [15:0] exp, input string req);
    start(s, rw, hw, d);
    wait_ready(8, got);
    chk(req, {31'd0, got}, 32'd1);
    if (rw) chk(req, {16'd0, hd_out}, {16'd0, exp});
    finish_cyc();
  endtask

  task automatic mem_take(input logic [31:0] exp, input string req);
    chk(req, {wr_req, wr_data[30:0]}, {1'b1, exp[30:0]});
    chk(req, {31'd0, wr_data[31]}, {31'd0, exp[31]});
    wr_ack = 1;
    @(negedge clk);
    wr_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset hrdy/req", {29'd0, hrdy, wr_req, rd_req}, 32'b100);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {29'd0, hrdy, wr_req, rd_req}, 32'b100);
    // R1 control register reset value
    start(2'b00, 1'b1, 1'b0, 16'h0);
    wait_ready(1, got);
    chk("R5 ctrl ready in one cycle", {31'd0, got}, 32'd1);
    chk("R1 ctrl reset value", {16'd0, hd_out}, 32'h0);
    finish_cyc();

    // R4 strobe without chip select
    @(negedge clk);
    hstrb_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 no ready without cs", {31'd0, hrdy}, 32'd1);
    end
    hstrb_n = 1;
    @(negedge clk);

    // R5 R6 table walk: control halfwords and data-port writes
    for (int i = 0; i < NV; i++)
      access(VEC[i][35:34], VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0], "R5/R6 table");

    // R9 R6 drain order, low half first
    mem_take(32'h2222_1111, "R9 R6 first word");
    mem_take(32'h4444_3333, "R9 second word");
    chk("R9 drained", {31'd0, wr_req}, 32'd0);

    // R2 read waits on empty FIFO, prefetch
    start(2'b01, 1'b1, 1'b0, 16'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 wait on empty", {30'd0, hrdy, rd_req}, 32'b11);
    end
    rd_data = 32'hCAFE_BEEF; rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
    chk("R2 ready after fill", {31'd0, hrdy}, 32'd0);
    chk("R6 low half read", {16'd0, hd_out}, 32'h0000_BEEF);
    finish_cyc();
    start(2'b01, 1'b1, 1'b1, 16'h0);
    @(negedge clk);
    chk("R6 no pop on first half", {31'd0, hrdy}, 32'd0);
    chk("R6 high half read", {16'd0, hd_out}, 32'h0000_CAFE);
    finish_cyc();

    // R7 relatch while not ready
    start(2'b01, 1'b1, 1'b0, 16'h0);
    @(negedge clk);
    @(negedge clk);
    chk("R6 pop after second half", {31'd0, hrdy}, 32'd1);
    hcntl = 2'b00;
    @(negedge clk);
    chk("R7 relatched to ctrl", {30'd0, hrdy, rd_req}, 32'b00);
    chk("R7 ctrl data", {16'd0, hd_out}, 32'h3C3C);
    finish_cyc();

    // R8 aborted read
    start(2'b01, 1'b1, 1'b0, 16'h0);
    @(negedge clk);
    finish_cyc();
    access(2'b00, 1'b1, 1'b0, 16'h0, 16'h3C3D, "R8 abort flag set");

    // R3 write to full FIFO, then R8 aborted write
    for (int i = 0; i < 4; i++) begin
      access(2'b01, 1'b0, 1'b0, 16'hA000 + 16'(i), 16'h0, "R3 fill low");
      access(2'b01, 1'b0, 1'b1, 16'hB000 + 16'(i), 16'h0, "R3 fill high");
    end
    start(2'b01, 1'b0, 1'b1, 16'h5555);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 wait on full", {31'd0, hrdy}, 32'd1);
    end
    finish_cyc();
    for (int i = 0; i < 4; i++)
      mem_take({16'hB000 + 16'(i), 16'hA000 + 16'(i)}, "R8 R9 fifo untouched by abort");
    chk("R8 no extra push", {31'd0, wr_req}, 32'd0);

    // R8 sticky: write with bit0=0 keeps it, bit0=1 clears
    access(2'b00, 1'b0, 1'b0, 16'h0F00, 16'h0, "R8 write keep");
    access(2'b00, 1'b1, 1'b1, 16'h0, 16'h0F01, "R8 flag sticky");
    access(2'b00, 1'b0, 1'b1, 16'h0F01, 16'h0, "R8 write clear");
    access(2'b00, 1'b1, 1'b0, 16'h0, 16'h0F00, "R8 flag cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule